// File: doc/BRIEF.md
# Descriptor-Chained LUT Refill Engine

This engine fills a two-dimensional address lookup table from a linked chain of refill descriptors held in memory. Each descriptor describes an inclusive rectangle of table cells, points at an array of 32-bit page addresses that supplies one value per cell, and points at the next descriptor. Software writes a descriptor address into the engine's command port. The engine then fetches each descriptor, streams its entry array into the table row by row, follows the chain to its end, and reports completion through status flags and a last-descriptor interrupt.

Memory is reached through a read port with a request/response handshake. Requests may be pipelined, and responses return in order. Table updates leave through a write port that carries the row, the column, the table index and the value. Writing zero to the command port abandons any work in flight. The engine then waits for outstanding reads to return and becomes ready again.

Top module: `lutRefillEngine`

## Requirements
- R1: After reset the status reads ready=1, err=0, valid=0 and done=0. The interrupt is low, and no memory request or table write is issued.
- R2: A non-zero command write accepted while ready starts a chain at that address and clears ready, valid and done. Reads are issued as word requests at consecutive 4-byte addresses.
- R3: A descriptor is five consecutive words: {y0,x0} with x0 in bits [15:0] and y0 in bits [31:16]; {y1,x1} in the same layout; a control word with the start flag in bit 0 and the table index in bits [11:8]; the entry array address; and the next descriptor address.
- R4: For a started descriptor the engine issues exactly (x1-x0+1)*(y1-y0+1) table writes. Rows run from y0 to y1 and, within a row, x advances first from x0 to x1. Write k carries row=y, column=x, the descriptor's table index and entry word k of the array.
- R5: A next address that is not zero causes that descriptor to be fetched and processed. A next address of zero ends the chain.
- R6: When the chain completes, ready, valid and done are all set and the last-descriptor interrupt rises. The interrupt stays high until an acknowledge pulse clears it.
- R7: A start, entry array or next descriptor address with any of bits [3:0] set raises err, leaves ready clear, and causes no table write for that descriptor.
- R8: A started descriptor with x1<x0 or y1<y0 raises err and writes nothing.
- R9: A descriptor whose start flag is clear makes no table writes, and the chain continues through its next address.
- R10: An error response from memory raises err and stops table writes at once. Ready stays clear until zero is written to the command port.
- R11: Writing zero to the command port stops the chain. Once all outstanding reads have returned, the status reads ready=1 with err, valid and done clear, and a following chain runs correctly.
- R12: A non-zero command write while the engine is not ready is ignored.
- R13: When memory accepts a request every cycle, the entries of one descriptor reach the table on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| descWrEn | input | 1 | Command port write strobe |
| descWrData | input | ADDR_W | Descriptor address (0 = cancel) |
| irqAck | input | 1 | Clears the last-descriptor interrupt |
| statErr | output | 1 | Error flag |
| statReady | output | 1 | Engine idle and able to accept a chain |
| statValid | output | 1 | Table contents from the last chain are valid |
| statDone | output | 1 | Last chain completed |
| irqLst | output | 1 | Last-descriptor interrupt |
| memReqValid | output | 1 | Memory read request |
| memReqAddr | output | ADDR_W | Memory read byte address |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Read data word |
| memRspErr | input | 1 | Read returned an error |
| lutWrEn | output | 1 | Table write strobe |
| lutWrRow | output | COORD_W | Table row (y) |
| lutWrCol | output | COORD_W | Table column (x) |
| lutWrLut | output | LUT_W | Table index |
| lutWrData | output | 32 | Page address written |

## Verification
The bench sweeps every rectangle from 1x1 to 4x4 at shifted origins. For each one it checks the number of writes and every row, column, table index and value in issue order. A cursor that wrapped on the wrong coordinate, or a count that was off by one, would misplace or drop cells. It runs chains that contain a skipped descriptor, with memory back-pressure applied, so a design that wrote the skipped cells or lost its place under stalls would be caught. It also injects faults: misaligned start, entry and link addresses, an inverted rectangle, and an error response in mid-array. In each case the write count must stop at exactly the cell before the fault, and ready must stay low. A cancel with reads still in flight is followed by a fresh chain, which exposes a design that lets stale responses land in the new descriptor.

// File: rtl/lut_refill_pkg.sv
package lut_refill_pkg;

  localparam int WORD_W        = 32;
  localparam int DESC_WORDS    = 5;
  localparam int ALIGN_BITS    = 4;
  localparam int Y_FIELD_LSB   = 16;
  localparam int CTRL_START    = 0;
  localparam int CTRL_LUT_LSB  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_EVAL,
    ST_ENTRY,
    ST_LINK,
    ST_FAULT,
    ST_DRAIN
  } state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic beginDesc;
    logic selNext;
    logic beginEntry;
    logic reqEn;
    logic takeDesc;
    logic takeEntry;
  } strobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic phaseLast;
    logic rspErr;
    logic startBit;
    logic areaBad;
    logic entryMisal;
    logic nextMisal;
    logic nextZero;
    logic drained;
  } dpstat_t;

endpackage

// File: rtl/lut_refill_dp.sv
module lut_refill_dp
  import lut_refill_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 8,
  parameter int LUT_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ADDR_W-1:0]   startAddr,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memReqReady,
  input  logic                memRspValid,
  input  logic [WORD_W-1:0]   memRspData,
  input  logic                memRspErr,
  output logic                lutWrEn,
  output logic [COORD_W-1:0]  lutWrRow,
  output logic [COORD_W-1:0]  lutWrCol,
  output logic [LUT_W-1:0]    lutWrLut,
  output logic [WORD_W-1:0]   lutWrData,
  output dpstat_t             dst
);

  localparam int SPAN_W = COORD_W + 1;
  localparam int CNT_W  = 2 * SPAN_W;

  logic [ADDR_W-1:0]  baseAddr;
  logic [CNT_W-1:0]   issued;
  logic [CNT_W-1:0]   received;
  logic [CNT_W-1:0]   target;
  logic [COORD_W-1:0] ax0, ay0, ax1, ay1;
  logic [COORD_W-1:0] curX, curY;
  logic [LUT_W-1:0]   lutId;
  logic               startBit;
  logic [ADDR_W-1:0]  entryAddr;
  logic [ADDR_W-1:0]  nextAddr;

  logic [SPAN_W-1:0]  spanX, spanY;
  logic [CNT_W-1:0]   cellCount;
  logic               reqFire;
  logic               takeWord;

  assign spanX     = {1'b0, ax1} - {1'b0, ax0} + SPAN_W'(1);
  assign spanY     = {1'b0, ay1} - {1'b0, ay0} + SPAN_W'(1);
  assign cellCount = CNT_W'(spanX) * CNT_W'(spanY);

  assign memReqValid = stb.reqEn && (issued != target);
  assign memReqAddr  = baseAddr + ADDR_W'({issued, 2'b00});
  assign reqFire     = memReqValid && memReqReady;
  assign takeWord    = stb.takeDesc && memRspValid && !memRspErr;

  // request / response accounting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      issued   <= '0;
      received <= '0;
      target   <= '0;
    end else if (stb.beginDesc) begin
      baseAddr <= stb.selNext ? nextAddr : startAddr;
      issued   <= '0;
      received <= '0;
      target   <= CNT_W'(DESC_WORDS);
    end else if (stb.beginEntry) begin
      baseAddr <= entryAddr;
      issued   <= '0;
      received <= '0;
      target   <= cellCount;
    end else begin
      if (reqFire)     issued   <= issued + CNT_W'(1);
      if (memRspValid) received <= received + CNT_W'(1);
    end
  end

  // descriptor word capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ax0 <= '0; ay0 <= '0; ax1 <= '0; ay1 <= '0;
      lutId     <= '0;
      startBit  <= 1'b0;
      entryAddr <= '0;
      nextAddr  <= '0;
    end else if (takeWord) begin
      case (received)
        CNT_W'(0): begin
          ax0 <= memRspData[COORD_W-1:0];
          ay0 <= memRspData[Y_FIELD_LSB +: COORD_W];
        end
        CNT_W'(1): begin
          ax1 <= memRspData[COORD_W-1:0];
          ay1 <= memRspData[Y_FIELD_LSB +: COORD_W];
        end
        CNT_W'(2): begin
          startBit <= memRspData[CTRL_START];
          lutId    <= memRspData[CTRL_LUT_LSB +: LUT_W];
        end
        CNT_W'(3): entryAddr <= memRspData[ADDR_W-1:0];
        CNT_W'(4): nextAddr  <= memRspData[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  // table write cursor, x advances first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curX <= '0;
      curY <= '0;
    end else if (stb.beginEntry) begin
      curX <= ax0;
      curY <= ay0;
    end else if (lutWrEn) begin
      if (curX == ax1) begin
        curX <= ax0;
        curY <= curY + COORD_W'(1);
      end else begin
        curX <= curX + COORD_W'(1);
      end
    end
  end

  assign lutWrEn   = stb.takeEntry && memRspValid && !memRspErr;
  assign lutWrRow  = curY;
  assign lutWrCol  = curX;
  assign lutWrLut  = lutId;
  assign lutWrData = memRspData;

  assign dst.phaseLast  = memRspValid && (received == target - CNT_W'(1));
  assign dst.rspErr     = memRspValid && memRspErr;
  assign dst.startBit   = startBit;
  assign dst.areaBad    = (ax1 < ax0) || (ay1 < ay0);
  assign dst.entryMisal = |entryAddr[ALIGN_BITS-1:0];
  assign dst.nextMisal  = |nextAddr[ALIGN_BITS-1:0];
  assign dst.nextZero   = (nextAddr == '0);
  assign dst.drained    = (issued == received);

  AST_ISSUE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    issued <= target) else $error("issued beyond target"); // R4
  AST_RSP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && stb.takeEntry) |-> (received < target)) else $error("response beyond issue"); // R4
  AST_CURSOR_IN_AREA: assert property (@(posedge clk) disable iff (!rstN)
    lutWrEn |-> (curX >= ax0 && curX <= ax1 && curY >= ay0 && curY <= ay1)) else $error("cursor left area"); // R4
  AST_REQ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00)) else $error("unaligned request"); // R2

endmodule

// File: rtl/lut_refill_ctrl.sv
module lut_refill_ctrl
  import lut_refill_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descWrEn,
  input  logic [ADDR_W-1:0] descWrData,
  input  logic              irqAck,
  input  dpstat_t           dst,
  output strobe_t           stb,
  output logic              statErr,
  output logic              statReady,
  output logic              statValid,
  output logic              statDone,
  output logic              irqLst
);

  state_t state, nextState;
  logic   cancel, launch, finish, enterFault;

  assign cancel = descWrEn && (descWrData == '0);
  assign launch = descWrEn && (descWrData != '0) && (state == ST_IDLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    finish    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (launch) begin
          if (|descWrData[ALIGN_BITS-1:0]) begin
            nextState = ST_FAULT;
          end else begin
            stb.beginDesc = 1'b1;
            nextState     = ST_DESC;
          end
        end
      end
      ST_DESC: begin
        stb.reqEn    = 1'b1;
        stb.takeDesc = 1'b1;
        if (dst.rspErr)         nextState = ST_FAULT;
        else if (dst.phaseLast) nextState = ST_EVAL;
      end
      ST_EVAL: begin
        if (!dst.startBit) begin
          nextState = ST_LINK;
        end else if (dst.areaBad || dst.entryMisal) begin
          nextState = ST_FAULT;
        end else begin
          stb.beginEntry = 1'b1;
          nextState      = ST_ENTRY;
        end
      end
      ST_ENTRY: begin
        stb.reqEn     = 1'b1;
        stb.takeEntry = 1'b1;
        if (dst.rspErr)         nextState = ST_FAULT;
        else if (dst.phaseLast) nextState = ST_LINK;
      end
      ST_LINK: begin
        if (dst.nextZero) begin
          finish    = 1'b1;
          nextState = ST_IDLE;
        end else if (dst.nextMisal) begin
          nextState = ST_FAULT;
        end else begin
          stb.beginDesc = 1'b1;
          stb.selNext   = 1'b1;
          nextState     = ST_DESC;
        end
      end
      ST_FAULT: nextState = ST_FAULT;
      ST_DRAIN: if (dst.drained) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
    if (cancel && state != ST_IDLE) begin
      stb       = '0;
      finish    = 1'b0;
      nextState = ST_DRAIN;
    end
  end

  assign enterFault = (nextState == ST_FAULT) && (state != ST_FAULT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      statErr   <= 1'b0;
      statValid <= 1'b0;
      statDone  <= 1'b0;
      irqLst    <= 1'b0;
    end else begin
      state <= nextState;
      if (cancel)          statErr <= 1'b0;
      else if (enterFault) statErr <= 1'b1;
      if (cancel || launch) begin
        statValid <= 1'b0;
        statDone  <= 1'b0;
      end else if (finish) begin
        statValid <= 1'b1;
        statDone  <= 1'b1;
      end
      if (finish)      irqLst <= 1'b1;
      else if (irqAck) irqLst <= 1'b0;
    end
  end

  assign statReady = (state == ST_IDLE);

  AST_READY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    statReady |-> !statErr) else $error("ready with error"); // R7
  AST_DONE_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
    statDone |-> (statValid && statReady)) else $error("done without ready/valid"); // R6
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (statErr && !cancel) |=> (statErr && !statReady)) else $error("fault released early"); // R10
  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cancel |=> (!statErr && !statDone && !statValid)) else $error("cancel left flags"); // R11
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (descWrEn && descWrData != '0 && state == ST_FAULT) |=> (state == ST_FAULT)) else $error("busy write accepted"); // R12

endmodule

// File: rtl/lutRefillEngine.sv
module lutRefillEngine
  import lut_refill_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 8,
  parameter int LUT_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                descWrEn,
  input  logic [ADDR_W-1:0]   descWrData,
  input  logic                irqAck,
  output logic                statErr,
  output logic                statReady,
  output logic                statValid,
  output logic                statDone,
  output logic                irqLst,
  output logic                memReqValid,
  output logic [ADDR_W-1:0]   memReqAddr,
  input  logic                memReqReady,
  input  logic                memRspValid,
  input  logic [31:0]         memRspData,
  input  logic                memRspErr,
  output logic                lutWrEn,
  output logic [COORD_W-1:0]  lutWrRow,
  output logic [COORD_W-1:0]  lutWrCol,
  output logic [LUT_W-1:0]    lutWrLut,
  output logic [31:0]         lutWrData
);

  strobe_t stb;
  dpstat_t dst;

  lut_refill_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .descWrEn   (descWrEn),
    .descWrData (descWrData),
    .irqAck     (irqAck),
    .dst        (dst),
    .stb        (stb),
    .statErr    (statErr),
    .statReady  (statReady),
    .statValid  (statValid),
    .statDone   (statDone),
    .irqLst     (irqLst)
  );

  lut_refill_dp #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .LUT_W(LUT_W)) dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .startAddr   (descWrData),
    .memReqValid (memReqValid),
    .memReqAddr  (memReqAddr),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspData  (memRspData),
    .memRspErr   (memRspErr),
    .lutWrEn     (lutWrEn),
    .lutWrRow    (lutWrRow),
    .lutWrCol    (lutWrCol),
    .lutWrLut    (lutWrLut),
    .lutWrData   (lutWrData),
    .dst         (dst)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    statReady |-> (!memReqValid && !lutWrEn)) else $error("activity while ready"); // R1
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLst) |-> statDone) else $error("interrupt without completion"); // R6

endmodule

// File: tb/lutRefillEngine_test.sv
`timescale 1ns/1ps
module lutRefillEngine_test;

  localparam int ADDR_W = 32;
  localparam int CW     = 4;
  localparam int LW     = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic descWrEn = 1'b0;
  logic [ADDR_W-1:0] descWrData = '0;
  logic irqAck = 1'b0;
  logic statErr, statReady, statValid, statDone, irqLst;
  logic memReqValid;
  logic [ADDR_W-1:0] memReqAddr;
  logic memReqReady = 1'b1;
  logic memRspValid;
  logic [31:0] memRspData;
  logic memRspErr;
  logic lutWrEn;
  logic [CW-1:0] lutWrRow, lutWrCol;
  logic [LW-1:0] lutWrLut;
  logic [31:0] lutWrData;

  always #2.5 clk = ~clk;

  lutRefillEngine #(.ADDR_W(ADDR_W), .COORD_W(CW), .LUT_W(LW)) uut (
    .clk(clk), .rstN(rstN), .descWrEn(descWrEn), .descWrData(descWrData), .irqAck(irqAck),
    .statErr(statErr), .statReady(statReady), .statValid(statValid), .statDone(statDone),
    .irqLst(irqLst), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspData(memRspData),
    .memRspErr(memRspErr), .lutWrEn(lutWrEn), .lutWrRow(lutWrRow), .lutWrCol(lutWrCol),
    .lutWrLut(lutWrLut), .lutWrData(lutWrData)
  );

  // memory model: two-cycle latency, in-order
  logic [31:0] mem [0:1023];
  logic [31:0] errAddr = 32'hFFFF_FFF0;
  logic p0v;
  logic [31:0] p0a;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p0v <= 1'b0; p0a <= '0; memRspValid <= 1'b0; memRspData <= '0; memRspErr <= 1'b0;
    end else begin
      p0v <= memReqValid && memReqReady;
      p0a <= memReqAddr;
      memRspValid <= p0v;
      memRspData  <= mem[p0a[11:2]];
      memRspErr   <= p0v && (p0a == errAddr);
    end
  end

  // back-pressure pattern
  bit stall = 1'b0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    memReqReady <= !(stall && (cyc % 3 == 0));
  end

  // table write monitor
  int wrCount = 0;
  int curRun = 0;
  int maxRun = 0;
  logic [CW-1:0] seqRow [0:255];
  logic [CW-1:0] seqCol [0:255];
  logic [LW-1:0] seqLut [0:255];
  logic [31:0]   seqData [0:255];
  always @(posedge clk) begin
    if (lutWrEn) begin
      if (wrCount < 256) begin
        seqRow[wrCount] = lutWrRow;
        seqCol[wrCount] = lutWrCol;
        seqLut[wrCount] = lutWrLut;
        seqData[wrCount] = lutWrData;
      end
      wrCount++;
      curRun++;
      if (curRun > maxRun) maxRun = curRun;
    end else begin
      curRun = 0;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int status();
    return {28'd0, statErr, statReady, statValid, statDone};
  endfunction

  task automatic putDesc(input int a, input int x0, input int y0, input int x1, input int y1,
                         input bit st, input int lut, input int ent, input int nxt);
    mem[a/4]   = 32'((y0 << 16) | x0);
    mem[a/4+1] = 32'((y1 << 16) | x1);
    mem[a/4+2] = 32'((lut << 8) | int'(st));
    mem[a/4+3] = 32'(ent);
    mem[a/4+4] = 32'(nxt);
  endtask

  task automatic fillEntries(input int a, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[a/4+i] = 32'(seed + i);
  endtask

  task automatic cmdWrite(input int v);
    @(negedge clk);
    descWrEn = 1'b1;
    descWrData = 32'(v);
    @(negedge clk);
    descWrEn = 1'b0;
  endtask

  task automatic settle();
    int n = 0;
    while (!(statReady || statErr) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic ackIrq();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic newRun();
    @(negedge clk);
    wrCount = 0;
    maxRun = 0;
  endtask

  // compare recorded writes against a row-major walk of the area
  task automatic checkArea(input int base, input int x0, input int y0, input int x1, input int y1,
                           input int lut, input int seed, input string tag);
    int k = 0;
    bit ok = 1'b1;
    int act = 0;
    int exp = 0;
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        if (ok && (int'(seqRow[base+k]) != y || int'(seqCol[base+k]) != x ||
                   int'(seqLut[base+k]) != lut || seqData[base+k] != 32'(seed + k))) begin
          ok = 1'b0;
          act = (int'(seqRow[base+k]) << 24) | (int'(seqCol[base+k]) << 16) | int'(seqData[base+k][15:0]);
          exp = (y << 24) | (x << 16) | ((seed + k) & 16'hFFFF);
        end
        k++;
      end
    end
    check(ok, tag, act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'(i * 7);
    fillEntries(32'h400, 16, 32'h1000);
    fillEntries(32'h600, 1, 32'h3000);
    fillEntries(32'h800, 256, 32'h8000);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status() == 4'b0100, "R1 reset status", status(), 4'b0100);
    check(!irqLst && !memReqValid && !lutWrEn, "R1 reset idle outputs", int'(irqLst), 0);

    // R2 R3 R4 R6: single descriptor, 4x3 area
    putDesc(32'h100, 2, 1, 5, 3, 1'b1, 1, 32'h400, 0);
    newRun();
    cmdWrite(32'h100);
    check(!statReady && !statDone, "R2 start clears ready", status(), 4'b0000);
    settle();
    check(wrCount == 12, "R4 write count 4x3", wrCount, 12);
    checkArea(0, 2, 1, 5, 3, 1, 32'h1000, "R3 R4 single area order");
    check(status() == 4'b0111, "R6 completion status", status(), 4'b0111);
    check(irqLst == 1'b1, "R6 interrupt raised", int'(irqLst), 1);
    ackIrq();
    check(irqLst == 1'b0, "R6 interrupt acknowledged", int'(irqLst), 0);

    // R5 R9: three-link chain with skipped middle, under back-pressure
    putDesc(32'h100, 0, 0, 2, 1, 1'b1, 1, 32'h400, 32'h140);
    putDesc(32'h140, 0, 0, 3, 3, 1'b0, 2, 32'h800, 32'h180);
    putDesc(32'h180, 7, 9, 7, 9, 1'b1, 3, 32'h600, 0);
    stall = 1'b1;
    newRun();
    cmdWrite(32'h100);
    settle();
    check(wrCount == 7, "R9 skipped descriptor writes nothing", wrCount, 7);
    checkArea(0, 0, 0, 2, 1, 1, 32'h1000, "R5 first link");
    checkArea(6, 7, 9, 7, 9, 3, 32'h3000, "R5 last link");
    check(status() == 4'b0111, "R5 chain completion", status(), 4'b0111);
    ackIrq();
    stall = 1'b0;

    // R4 R13 sweep of area shapes
    for (int w = 1; w <= 4; w++) begin
      for (int h = 1; h <= 4; h++) begin
        int seed = (w << 12) | (h << 8);
        fillEntries(32'hC00, w*h, seed);
        putDesc(32'h300, w, h, 2*w-1, 2*h-1, 1'b1, (w+h) & 3, 32'hC00, 0);
        newRun();
        cmdWrite(32'h300);
        settle();
        check(wrCount == w*h && statDone, "R4 sweep count", wrCount, w*h);
        checkArea(0, w, h, 2*w-1, 2*h-1, (w+h) & 3, seed, "R4 sweep order");
        check(maxRun == w*h, "R13 back-to-back writes", maxRun, w*h);
      end
    end
    ackIrq();

    // R7 misaligned start address, then R11 recovery
    newRun();
    cmdWrite(32'h104);
    settle();
    check(status() == 4'b1000 && wrCount == 0, "R7 misaligned start", status(), 4'b1000);
    cmdWrite(0);
    settle();
    check(status() == 4'b0100, "R11 cancel after fault", status(), 4'b0100);

    // R7 misaligned entry array
    putDesc(32'h340, 0, 0, 1, 1, 1'b1, 0, 32'h408, 0);
    newRun();
    cmdWrite(32'h340);
    settle();
    check(status() == 4'b1000 && wrCount == 0, "R7 misaligned entry array", status(), 4'b1000);
    cmdWrite(0);
    settle();

    // R7 misaligned next link
    putDesc(32'h380, 0, 0, 0, 0, 1'b1, 0, 32'h400, 32'h148);
    newRun();
    cmdWrite(32'h380);
    settle();
    check(status() == 4'b1000 && wrCount == 1, "R7 misaligned next link", wrCount, 1);
    cmdWrite(0);
    settle();

    // R8 inverted area
    putDesc(32'h3C0, 3, 0, 1, 2, 1'b1, 0, 32'h400, 0);
    newRun();
    cmdWrite(32'h3C0);
    settle();
    check(status() == 4'b1000 && wrCount == 0, "R8 inverted area", status(), 4'b1000);
    cmdWrite(0);
    settle();

    // R10 memory error response in mid-array
    putDesc(32'h3C0, 0, 0, 3, 3, 1'b1, 0, 32'h800, 0);
    errAddr = 32'h814;
    newRun();
    cmdWrite(32'h3C0);
    settle();
    repeat (20) @(negedge clk);
    check(wrCount == 5, "R10 writes stop at error", wrCount, 5);
    check(status() == 4'b1000, "R10 ready held clear", status(), 4'b1000);
    errAddr = 32'hFFFF_FFF0;
    cmdWrite(0);
    settle();
    check(status() == 4'b0100, "R10 released by zero write", status(), 4'b0100);

    // R12 command write while busy is ignored
    putDesc(32'h240, 0, 0, 7, 3, 1'b1, 2, 32'h800, 0);
    stall = 1'b1;
    newRun();
    cmdWrite(32'h240);
    repeat (10) @(negedge clk);
    cmdWrite(32'h100);
    settle();
    check(wrCount == 32, "R12 busy write ignored count", wrCount, 32);
    checkArea(0, 0, 0, 7, 3, 2, 32'h8000, "R12 busy write ignored order");
    ackIrq();

    // R11 cancel with reads in flight, then a clean chain
    putDesc(32'h1C0, 0, 0, 15, 15, 1'b1, 1, 32'h800, 0);
    newRun();
    cmdWrite(32'h1C0);
    repeat (40) @(negedge clk);
    cmdWrite(0);
    settle();
    check(status() == 4'b0100 && !irqLst, "R11 cancel returns ready", status(), 4'b0100);
    check(wrCount > 0 && wrCount < 256, "R11 cancel stops writes", wrCount, 128);
    stall = 1'b0;
    putDesc(32'h200, 1, 1, 2, 2, 1'b1, 3, 32'h400, 0);
    newRun();
    cmdWrite(32'h200);
    settle();
    check(wrCount == 4, "R11 post-cancel count", wrCount, 4);
    checkArea(0, 1, 1, 2, 2, 3, 32'h1000, "R11 post-cancel order");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule